// File: doc/BRIEF.md
# Receive Destination Address Filter

This block decides, for each incoming Ethernet frame, whether the frame is kept. It looks only at the 48-bit destination address. The receive path presents the address with a one-cycle strobe, and the verdict comes back on the next cycle.

The decision draws on four exact-match station address slots, each with its own enable. Broadcast, multicast and promiscuous behaviour are set by bits in a control word. Multicast addresses can also be filtered through a 64-bit hash table. The hash index is derived inside the block from a CRC-32 over the six address bytes. All settings are loaded through a one-cycle register write port.

The result carries three signals: an accept bit, a flag for broadcast acceptance, and a flag for multicast acceptance. The receive logic can use these to tag or count frames.

Top module: `rxaf_top`

## Requirements
- R1: After reset, the control word, both hash registers and all station slots are zero, and `res_valid`, `accept`, `bcast_hit` and `mcast_hit` are low. With these settings, every non-promiscuous frame is rejected.
- R2: `res_valid` is high exactly one cycle after a cycle with `da_valid` high, and low otherwise. `accept`, `bcast_hit` and `mcast_hit` are low whenever `res_valid` is low.
- R3: The write port uses these `cfg_addr` values:
  - 0: control word.
  - 1: hash register 0.
  - 2: hash register 1.
  - 4+2k: low word of slot k.
  - 5+2k: high word of slot k.
  - Any other address: the write is ignored.
  A frame presented in the same cycle as a write is judged with the settings in force before that write.
- R4: `da[47:40]` is address byte 0, the first byte on the wire, and `da[7:0]` is byte 5. A slot's high word holds byte 0 in bits 15:8 and byte 1 in bits 7:0. Its low word holds bytes 2, 3, 4 and 5 in bits 31:24, 23:16, 15:8 and 7:0.
- R5: Control bits 4+k enable slot k. A frame whose address equals any enabled slot is accepted. The contents of a disabled slot have no effect.
- R6: The all-ones address is broadcast. It sets `bcast_hit` and is accepted when control bit 3 is set. A broadcast never sets `mcast_hit`, whatever the multicast settings.
- R7: A non-broadcast address with `da[40]` = 1 is multicast. When control bit 1 is set, every multicast frame is accepted with `mcast_hit`.
- R8: Control bit 2 enables hashed multicast. The hash index is the top 6 bits of a reflected CRC-32 over bytes 0 to 5, processed byte 0 first and least significant bit first. The CRC uses polynomial 0xEDB88320, starts from all ones and is not inverted at the end. Index bits 5:4 pick a 16-bit word and bits 3:0 pick bit 15−low within it. Hash register 0 holds word 0 in bits 15:0 and word 1 in bits 31:16; hash register 1 holds words 2 and 3 the same way. A set bit accepts the frame with `mcast_hit`.
- R9: A unicast address (`da[40]` = 0) never sets `mcast_hit`. Neither the hash table nor control bit 1 makes it accepted.
- R10: Control bit 0 (promiscuous) accepts every frame. `bcast_hit` and `mcast_hit` still follow R6 to R8 alone.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr_en | input | 1 | Register write strobe |
| cfg_addr | input | 4 | Register write address |
| cfg_wdata | input | 32 | Register write data |
| da_valid | input | 1 | Destination address strobe |
| da | input | 48 | Destination address, byte 0 in bits 47:40 |
| res_valid | output | 1 | Verdict valid, one cycle after `da_valid` |
| accept | output | 1 | Frame accepted |
| bcast_hit | output | 1 | Accepted-broadcast flag |
| mcast_hit | output | 1 | Accepted-multicast flag |

## Verification
The bench targets the corner cases below; each names the fault it would expose.
- **CRC bit or byte order.** The bench derives the hash index with a forward CRC and bit-reverses the result. A design with a swapped CRC order would set or test the wrong hash bit, and a multicast that should be accepted would be rejected.
- **Station word layout.** Addresses that differ only in byte 0 or only in byte 5 show whether a slot's bytes are packed in the right order.
- **Broadcast overlap.** A broadcast with all multicast enables on must raise `bcast_hit` and never `mcast_hit`. A design that misses the all-ones check would accept broadcast through the hash.
- **Unicast overlap.** A unicast address with a full hash table must be rejected.
- **Same-cycle writes.** A frame presented in the same cycle as an enable write must use the old setting. A design that bypasses the write into the decision would accept that frame early.

// File: rtl/rxaf_pkg.sv
package rxaf_pkg;

  localparam int MAC_W      = 48;
  localparam int REG_DW     = 32;
  localparam int HASH_IDX_W = 6;
  localparam int HASH_BITS  = 1 << HASH_IDX_W;
  localparam int SLOT_BASE  = 4;
  localparam int CTRL_BASIC = 4;

  // Control word, low nibble; bit order is part of the register contract.
  typedef struct packed {
    logic bcast;    // bit3
    logic hash_mc;  // bit2
    logic all_mc;   // bit1
    logic promisc;  // bit0
  } ctrl_t;

  // Reflected CRC-32 over the address bytes, first byte first, LSB first;
  // returns only the six top bits that index the hash table.
  function automatic logic [HASH_IDX_W-1:0] hash_index(input logic [MAC_W-1:0] mac);
    logic [31:0] crc;
    logic [7:0]  byte_v;
    logic        fb;
    crc = 32'hFFFF_FFFF;
    for (int b = 0; b < MAC_W / 8; b++) begin
      byte_v = mac[MAC_W-1-8*b -: 8];
      for (int i = 0; i < 8; i++) begin
        fb  = crc[0] ^ byte_v[i];
        crc = crc >> 1;
        if (fb) crc = crc ^ 32'hEDB8_8320;
      end
    end
    return crc[31:32-HASH_IDX_W];
  endfunction

  // Flat table position: word select kept, bit within word reversed.
  function automatic logic [HASH_IDX_W-1:0] hash_pos(input logic [HASH_IDX_W-1:0] idx);
    return {idx[HASH_IDX_W-1:4], ~idx[3:0]};
  endfunction

endpackage

// File: rtl/rxaf_regs.sv
module rxaf_regs
  import rxaf_pkg::*;
#(
  parameter int NUM_SLOTS = 4,
  parameter int AW        = 4
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              wr_en,
  input  logic [AW-1:0]                     wr_addr,
  input  logic [REG_DW-1:0]                 wr_data,
  output ctrl_t                             ctrl,
  output logic [NUM_SLOTS-1:0]              slot_en,
  output logic [HASH_BITS-1:0]              hash_tbl,
  output logic [NUM_SLOTS-1:0][MAC_W-1:0]   slot_mac
);

  localparam int CTRL_W = CTRL_BASIC + NUM_SLOTS;
  localparam logic [AW-1:0] CTRL_A  = AW'(0);
  localparam logic [AW-1:0] HASH0_A = AW'(1);
  localparam logic [AW-1:0] HASH1_A = AW'(2);

  logic [CTRL_W-1:0] ctrl_q;
  logic [REG_DW-1:0] hash0_q, hash1_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q  <= '0;
      hash0_q <= '0;
      hash1_q <= '0;
    end else if (wr_en) begin
      if (wr_addr == CTRL_A)  ctrl_q  <= wr_data[CTRL_W-1:0];
      if (wr_addr == HASH0_A) hash0_q <= wr_data;
      if (wr_addr == HASH1_A) hash1_q <= wr_data;
    end
  end

  assign ctrl     = ctrl_t'(ctrl_q[CTRL_BASIC-1:0]);
  assign slot_en  = ctrl_q[CTRL_W-1:CTRL_BASIC];
  assign hash_tbl = {hash1_q, hash0_q};

  for (genvar k = 0; k < NUM_SLOTS; k++) begin : g_slot
    localparam logic [AW-1:0] LO_A = AW'(SLOT_BASE + 2*k);
    localparam logic [AW-1:0] HI_A = AW'(SLOT_BASE + 2*k + 1);
    logic [REG_DW-1:0]       lo_q;
    logic [MAC_W-REG_DW-1:0] hi_q;

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        lo_q <= '0;
        hi_q <= '0;
      end else if (wr_en) begin
        if (wr_addr == LO_A) lo_q <= wr_data;
        if (wr_addr == HI_A) hi_q <= wr_data[MAC_W-REG_DW-1:0];
      end
    end

    assign slot_mac[k] = {hi_q, lo_q};
  end

endmodule

// File: rtl/rxaf_hash.sv
module rxaf_hash
  import rxaf_pkg::*;
(
  input  logic [MAC_W-1:0]      mac,
  input  logic [HASH_BITS-1:0]  tbl,
  output logic [HASH_IDX_W-1:0] idx,
  output logic                  hit
);

  logic [HASH_IDX_W-1:0] pos;

  always_comb begin
    idx = hash_index(mac);
    pos = hash_pos(idx);
    hit = tbl[pos];
  end

endmodule

// File: rtl/rxaf_match.sv
module rxaf_match
  import rxaf_pkg::*;
#(
  parameter int NUM_SLOTS = 4
) (
  input  logic [MAC_W-1:0]                mac,
  input  logic [NUM_SLOTS-1:0][MAC_W-1:0] slot_mac,
  input  logic [NUM_SLOTS-1:0]            slot_en,
  output logic [NUM_SLOTS-1:0]            slot_hit,
  output logic                            any_hit
);

  for (genvar k = 0; k < NUM_SLOTS; k++) begin : g_cmp
    assign slot_hit[k] = slot_en[k] && (slot_mac[k] == mac);
  end

  assign any_hit = |slot_hit;

endmodule

// File: rtl/rxaf_top.sv
module rxaf_top
  import rxaf_pkg::*;
#(
  parameter int NUM_SLOTS = 4
) (
  input  logic                                        clk,
  input  logic                                        rst_n,
  input  logic                                        cfg_wr_en,
  input  logic [$clog2(SLOT_BASE+2*NUM_SLOTS)-1:0]    cfg_addr,
  input  logic [31:0]                                 cfg_wdata,
  input  logic                                        da_valid,
  input  logic [47:0]                                 da,
  output logic                                        res_valid,
  output logic                                        accept,
  output logic                                        bcast_hit,
  output logic                                        mcast_hit
);

  localparam int AW = $clog2(SLOT_BASE + 2*NUM_SLOTS);

  ctrl_t                           ctrl;
  logic [NUM_SLOTS-1:0]            slot_en;
  logic [HASH_BITS-1:0]            hash_tbl;
  logic [NUM_SLOTS-1:0][MAC_W-1:0] slot_mac;
  logic [NUM_SLOTS-1:0]            slot_hit;
  logic                            station_any;
  logic [HASH_IDX_W-1:0]           hash_idx;
  logic                            hash_hit;

  rxaf_regs #(.NUM_SLOTS(NUM_SLOTS), .AW(AW)) regs_i (
    .clk(clk), .rst_n(rst_n),
    .wr_en(cfg_wr_en), .wr_addr(cfg_addr), .wr_data(cfg_wdata),
    .ctrl(ctrl), .slot_en(slot_en), .hash_tbl(hash_tbl), .slot_mac(slot_mac)
  );

  rxaf_hash hash_i (
    .mac(da), .tbl(hash_tbl), .idx(hash_idx), .hit(hash_hit)
  );

  rxaf_match #(.NUM_SLOTS(NUM_SLOTS)) match_i (
    .mac(da), .slot_mac(slot_mac), .slot_en(slot_en),
    .slot_hit(slot_hit), .any_hit(station_any)
  );

  // Address class and next-cycle verdict
  logic is_bcast, is_mcast;
  logic bc_d, mc_d, acc_d;

  always_comb begin
    is_bcast = &da;
    is_mcast = da[40] && !is_bcast;
    bc_d     = is_bcast && ctrl.bcast;
    mc_d     = is_mcast && (ctrl.all_mc || (ctrl.hash_mc && hash_hit));
    acc_d    = ctrl.promisc || station_any || bc_d || mc_d;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      res_valid <= 1'b0;
      accept    <= 1'b0;
      bcast_hit <= 1'b0;
      mcast_hit <= 1'b0;
    end else begin
      res_valid <= da_valid;
      accept    <= da_valid && acc_d;
      bcast_hit <= da_valid && bc_d;
      mcast_hit <= da_valid && mc_d;
    end
  end

  AST_LATENCY:       assert property (@(posedge clk) disable iff (!rst_n) da_valid |=> res_valid); // R2
  AST_IDLE_QUIET:    assert property (@(posedge clk) disable iff (!rst_n)
                       !da_valid |=> (!res_valid && !accept && !bcast_hit && !mcast_hit)); // R2
  AST_STATION_ACC:   assert property (@(posedge clk) disable iff (!rst_n)
                       (da_valid && station_any) |=> accept); // R5
  AST_BCAST_EXCL:    assert property (@(posedge clk) disable iff (!rst_n)
                       !(bcast_hit && mcast_hit)); // R6
  AST_HIT_ACCEPTS:   assert property (@(posedge clk) disable iff (!rst_n)
                       (bcast_hit || mcast_hit) |-> accept); // R7
  AST_UNICAST_NO_MC: assert property (@(posedge clk) disable iff (!rst_n)
                       (da_valid && !da[40]) |=> !mcast_hit); // R9
  AST_PROMISC_ACC:   assert property (@(posedge clk) disable iff (!rst_n)
                       (da_valid && ctrl.promisc) |=> accept); // R10
  AST_HASH_ACC:      assert property (@(posedge clk) disable iff (!rst_n)
                       (da_valid && da[40] && !(&da) && ctrl.hash_mc && hash_hit) |=> mcast_hit); // R8

endmodule

// File: tb/rxaf_top_tb_top.sv
module rxaf_top_tb_top;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        cfg_wr_en;
  logic [3:0]  cfg_addr;
  logic [31:0] cfg_wdata;
  logic        da_valid;
  logic [47:0] da;
  logic        res_valid, accept, bcast_hit, mcast_hit;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rxaf_top dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_wr_en(cfg_wr_en), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .da_valid(da_valid), .da(da),
    .res_valid(res_valid), .accept(accept), .bcast_hit(bcast_hit), .mcast_hit(mcast_hit)
  );

  // Behavioural model state
  logic [7:0]  m_ctrl;
  logic [31:0] m_h0, m_h1;
  logic [31:0] m_lo [4];
  logic [15:0] m_hi [4];

  // Forward (non-reflected) CRC, bits fed LSB first; reversing its low six
  // bits gives the top six bits of the reflected CRC.
  function automatic int idx_of(input logic [47:0] d);
    logic [31:0] c;
    logic        bit_v;
    int          r;
    c = 32'hFFFF_FFFF;
    for (int n = 0; n < 48; n++) begin
      bit_v = d[47 - 8*(n/8) - 7 + (n%8)];
      if (c[31] ^ bit_v) c = (c << 1) ^ 32'h04C1_1DB7;
      else               c = c << 1;
    end
    r = 0;
    for (int j = 0; j < 6; j++) r = r * 2 + int'(c[j]);
    return r;
  endfunction

  function automatic logic hash_bit(input logic [47:0] d);
    int idx, word, pos;
    idx  = idx_of(d);
    word = idx / 16;
    pos  = (word % 2) * 16 + (15 - idx % 16);
    return (word < 2) ? m_h0[pos] : m_h1[pos];
  endfunction

  // Returns the hash register (1 or 2) and a data word with only d's bit set
  task automatic hash_loc(input logic [47:0] d, output logic [3:0] ra, output logic [31:0] rv);
    int idx, word;
    idx  = idx_of(d);
    word = idx / 16;
    ra   = (word < 2) ? 4'd1 : 4'd2;
    rv   = 32'd1 << ((word % 2) * 16 + (15 - idx % 16));
  endtask

  task automatic model_decide(input logic [47:0] d, output logic a, output logic b, output logic m);
    logic bc, mc, st;
    bc = &d;
    mc = d[40] && !bc;
    st = 1'b0;
    for (int k = 0; k < 4; k++)
      if (m_ctrl[4+k] && ({m_hi[k], m_lo[k]} == d)) st = 1'b1;
    b = bc && m_ctrl[3];
    m = mc && (m_ctrl[1] || (m_ctrl[2] && hash_bit(d)));
    a = m_ctrl[0] || st || b || m;
  endtask

  task automatic model_write(input logic [3:0] a, input logic [31:0] v);
    case (a)
      4'd0: m_ctrl = v[7:0];
      4'd1: m_h0 = v;
      4'd2: m_h1 = v;
      default: if (a >= 4 && a <= 11) begin
        if (a[0]) m_hi[(a-4)/2] = v[15:0];
        else      m_lo[(a-4)/2] = v;
      end
    endcase
  endtask

  task automatic chk(input logic act, input logic exp, input string req, input string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0b expected %0b at %0t", req, what, act, exp, $time);
    end
  endtask

  // One cycle: expectation from settings before this cycle's write
  task automatic step(input logic we, input logic [3:0] wa, input logic [31:0] wd,
                      input logic v, input logic [47:0] d, input string req);
    logic ea, eb, em;
    model_decide(d, ea, eb, em);
    if (!v) begin ea = 0; eb = 0; em = 0; end
    if (we) model_write(wa, wd);
    cfg_wr_en = we; cfg_addr = wa; cfg_wdata = wd; da_valid = v; da = d;
    @(posedge clk);
    @(negedge clk);
    chk(res_valid, v,  req, "res_valid");
    chk(accept,    ea, req, "accept");
    chk(bcast_hit, eb, req, "bcast_hit");
    chk(mcast_hit, em, req, "mcast_hit");
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] v, input string req);
    step(1'b1, a, v, 1'b0, 48'h0, req);
  endtask

  task automatic frame(input logic [47:0] d, input string req);
    step(1'b0, 4'd0, 32'd0, 1'b1, d, req);
  endtask

  task automatic set_slot(input int k, input logic [47:0] mac, input string req);
    wr(4'(4 + 2*k), mac[31:0], req);
    wr(4'(5 + 2*k), {16'h0, mac[47:32]}, req);
  endtask

  initial begin : watchdog
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  localparam logic [47:0] UA = 48'h0211_2233_4455;
  localparam logic [47:0] UB = 48'h00AA_BBCC_DDEE;
  localparam logic [47:0] BC = 48'hFFFF_FFFF_FFFF;
  localparam logic [47:0] MC = 48'h0100_5E00_0001;

  initial begin : main
    logic [3:0]  ha;
    logic [31:0] hv;
    logic [47:0] mcs [6];
    m_ctrl = 0; m_h0 = 0; m_h1 = 0;
    for (int k = 0; k < 4; k++) begin m_lo[k] = 0; m_hi[k] = 0; end
    rst_n = 0; cfg_wr_en = 0; cfg_addr = 0; cfg_wdata = 0; da_valid = 0; da = 0;
    repeat (3) @(negedge clk);
    chk(res_valid, 0, "R1", "res_valid in reset");
    chk(accept,    0, "R1", "accept in reset");
    rst_n = 1;
    // R1: defaults reject everything
    frame(UA, "R1"); frame(BC, "R1"); frame(MC, "R1");
    // R2: idle cycle after a frame, back-to-back frames
    step(0, 0, 0, 0, 48'h0, "R2");
    frame(UB, "R2"); frame(UA, "R2");
    // R5: disabled slot ignored, then enabled
    set_slot(0, UA, "R5");
    frame(UA, "R5");
    wr(4'd0, 32'h10, "R5");
    frame(UA, "R5");
    // R4: near misses in byte 0 and byte 5
    frame(48'h0311_2233_4455, "R4"); frame(48'h0211_2233_4454, "R4");
    set_slot(2, UB, "R5");
    frame(UB, "R5");
    wr(4'd0, 32'h50, "R5");
    frame(UB, "R5"); frame(UA, "R5");
    // R3: unused addresses ignored
    wr(4'd3, 32'hFFFF_FFFF, "R3"); wr(4'd13, 32'hFFFF_FFFF, "R3");
    frame(48'h0000_0000_0000, "R3"); frame(UB, "R3");
    // R3: same-cycle write uses old setting
    step(1, 4'd0, 32'h08, 1, BC, "R3");
    frame(BC, "R6");
    // R6: broadcast with all multicast enables never mcast
    wr(4'd0, 32'h0E, "R6");
    frame(BC, "R6");
    wr(4'd1, 32'hFFFF_FFFF, "R6"); wr(4'd2, 32'hFFFF_FFFF, "R6");
    frame(BC, "R6");
    wr(4'd0, 32'h06, "R6");
    frame(BC, "R6");
    // R9: unicast with full hash and all-multicast
    frame(UA, "R9"); frame(48'h0000_0000_0001, "R9");
    // R7: all multicast
    wr(4'd1, 0, "R7"); wr(4'd2, 0, "R7"); wr(4'd0, 32'h02, "R7");
    frame(MC, "R7"); frame(48'h3300_0000_0001, "R7");
    // R8: hash, single correct bit, then complementary bits
    mcs[0] = MC; mcs[1] = 48'h3333_0000_0001; mcs[2] = 48'h0180_C200_0000;
    mcs[3] = 48'h0100_5E7F_FFFA; mcs[4] = 48'h0900_2B00_0001; mcs[5] = 48'hABCD_EF01_2345;
    wr(4'd0, 32'h04, "R8");
    for (int i = 0; i < 6; i++) begin
      frame(mcs[i], "R8");
      hash_loc(mcs[i], ha, hv);
      wr(ha, hv, "R8"); wr(ha == 4'd1 ? 4'd2 : 4'd1, 0, "R8");
      frame(mcs[i], "R8");
      wr(ha, ~hv, "R8"); wr(ha == 4'd1 ? 4'd2 : 4'd1, 32'hFFFF_FFFF, "R8");
      frame(mcs[i], "R8");
    end
    // R10: promiscuous
    wr(4'd1, 0, "R10"); wr(4'd2, 0, "R10"); wr(4'd0, 32'h01, "R10");
    frame(UA, "R10"); frame(BC, "R10"); frame(MC, "R10");
    wr(4'd0, 32'h0F, "R10");
    frame(BC, "R10"); frame(MC, "R10");
    // Mixed traffic against the model
    for (int i = 0; i < 400; i++) begin
      logic [47:0] d;
      int sel;
      sel = $urandom_range(0, 7);
      case (sel)
        0: d = BC;
        1: d = UA;
        2: d = UB;
        3: d = mcs[$urandom_range(0, 5)];
        default: d = {$urandom, $urandom} & 48'hFFFF_FFFF_FFFF;
      endcase
      if ($urandom_range(0, 3) == 0)
        step(1, 4'($urandom_range(0, 12)), $urandom, $urandom_range(0, 1) == 1, d, "R8");
      else
        step(0, 0, 0, $urandom_range(0, 3) != 0, d, "R5");
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule